// File: doc/BRIEF.md
# Packed 16-bit Lane Multiply, Reduce and Difference Unit

This unit takes two 64-bit packed operands and a 64-bit accumulator value and returns one 64-bit result. A 4-bit operation code picks the function. The functions are: multiply-add of adjacent 16-bit lane pairs, sum of absolute differences over byte or halfword lanes, per-lane 16-bit products keeping the low or high half, a four-lane product reduction, and three accumulate forms that add signed products into the accumulator input. A signed flag chooses between sign extension and zero extension of the 16-bit lanes for the pairwise, per-lane and reduction forms. The accumulate forms always treat their operands as signed. The difference sums always treat their lanes as unsigned.

The datapath is combinational and ends in one result register. A transfer is offered with `valid_in`. The register captures on that cycle, and `valid_out` rises on the next cycle. The output side is tracked by a two-state machine. ST_IDLE means no fresh result is held. ST_RESULT means the result register holds a value captured on the previous cycle. The machine goes from ST_IDLE to ST_RESULT and stays in ST_RESULT while `valid_in` is high. It goes from ST_RESULT to ST_IDLE, or stays in ST_IDLE, while `valid_in` is low. Synchronous reset forces ST_IDLE and clears the result.

Top module: `smac_unit`

## Requirements
- R1: A synchronous reset, seen at a rising edge, leaves `valid_out` low and `result` zero after that edge.
- R2: `valid_out` is high exactly in the cycle after a cycle with `valid_in` high, and `result` then holds that transfer's value. When `valid_in` is low, `result` keeps its previous value.
- R3: Opcode 0 (pairwise multiply-add): the products of lanes 0 and 1 (16-bit lane k is bits 16k+15:16k) with the matching lanes of B are summed, truncated to 32 bits and placed in bits 31:0. Lanes 2 and 3 are handled the same way and placed in bits 63:32.
- R4: For opcodes 0, 3, 4 and 5, `is_signed`=1 sign-extends each 16-bit lane before multiplying, and `is_signed`=0 zero-extends it.
- R5: Opcode 1: the result is the zero-extended sum of the absolute differences of the eight unsigned byte lanes. Its maximum value is 2040.
- R6: Opcode 2: the result is the zero-extended sum of the absolute differences of the four unsigned 16-bit lanes.
- R7: Opcode 3 places bits 15:0 of each lane product in that lane's position. Opcode 4 places bits 31:16 of each lane product there.
- R8: Opcode 5: the result is the exact sum of the four lane products. It is sign-extended to 64 bits in the signed form and zero-extended in the unsigned form.
- R9: Opcode 6: the result is `acc_in` plus the signed 64-bit product of A[31:0] and B[31:0], modulo 2^64.
- R10: Opcode 7: the result is `acc_in` plus the sign-extended signed products of A[15:0]*B[15:0] and A[31:16]*B[31:16].
- R11: Opcode 8: the result is `acc_in` plus the sign-extended signed product of A[15:0] and B[15:0].
- R12: Opcodes 9 to 15 produce a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Operands and opcode are valid this cycle |
| opcode | input | 4 | Operation select |
| is_signed | input | 1 | Lane sign extension for opcodes 0, 3, 4, 5 |
| op_a | input | 64 | Packed operand A |
| op_b | input | 64 | Packed operand B |
| acc_in | input | 64 | Accumulator input for opcodes 6 to 8 |
| valid_out | output | 1 | Result register holds a fresh result |
| result | output | 64 | Registered result |

## Verification
Every opcode is driven with both settings of the signed flag. Each one is tried with lanes at the most negative value 0x8000, with all-ones lanes, with full-scale A against zero B, and with mixed 0x7FFF/0x8000 lanes. The 0x8000 and all-ones patterns separate sign extension from zero extension and catch a wrong high-half pick. Full-scale against zero drives both difference sums to their maxima. The mixed pattern exposes an error in the sign of the difference or a swapped lane pair. Random operands and accumulators, with idle gaps between transfers and a reset in the middle of the run, cover placement, wrap-around of the 32-bit pair sums, result hold and the handshake timing.

// File: rtl/smac_pkg.sv
package smac_pkg;
    localparam int WORD_W = 64;
    localparam int HALF_W = 16;
    localparam int BYTE_W = 8;
    localparam int N_HALF = WORD_W / HALF_W;
    localparam int N_BYTE = WORD_W / BYTE_W;
    localparam int PROD_W = 2 * HALF_W + 1;

    typedef enum logic [3:0] {
        OP_PAIR_MADD = 4'd0,
        OP_SAD_BYTE  = 4'd1,
        OP_SAD_HALF  = 4'd2,
        OP_MUL_LO    = 4'd3,
        OP_MUL_HI    = 4'd4,
        OP_MAC_SUM   = 4'd5,
        OP_ACC_W32   = 4'd6,
        OP_ACC_H2    = 4'd7,
        OP_ACC_H0    = 4'd8
    } op_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } vstate_e;
endpackage

// File: rtl/smac_lane_mul.sv
module smac_lane_mul #(
    parameter int LANE_W = 16,
    parameter int NLANES = 4,
    localparam int PW    = 2 * LANE_W + 1
) (
    input  logic [NLANES*LANE_W-1:0] a,
    input  logic [NLANES*LANE_W-1:0] b,
    input  logic                     is_signed,
    output logic [NLANES-1:0][PW-1:0] prod
);
    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        logic [LANE_W-1:0] la, lb;
        logic              xa, xb;
        logic [PW-1:0]     wa, wb;
        assign la = a[i*LANE_W +: LANE_W];
        assign lb = b[i*LANE_W +: LANE_W];
        assign xa = is_signed & la[LANE_W-1];
        assign xb = is_signed & lb[LANE_W-1];
        assign wa = {{(LANE_W+1){xa}}, la};
        assign wb = {{(LANE_W+1){xb}}, lb};
        assign prod[i] = wa * wb;

        always_comb begin
            // R4
            unsigned_prod_chk: assert (is_signed || !prod[i][PW-1]);
        end
    end
endmodule

// File: rtl/smac_sad.sv
module smac_sad #(
    parameter int LANE_W = 8,
    parameter int NLANES = 8,
    localparam int SUM_W = LANE_W + $clog2(NLANES)
) (
    input  logic [NLANES*LANE_W-1:0] a,
    input  logic [NLANES*LANE_W-1:0] b,
    output logic [SUM_W-1:0]         sum
);
    localparam logic [SUM_W-1:0] MAX_SUM = SUM_W'(NLANES * ((1 << LANE_W) - 1));

    always_comb begin
        logic [LANE_W-1:0] la, lb, d;
        sum = '0;
        for (int i = 0; i < NLANES; i++) begin
            la  = a[i*LANE_W +: LANE_W];
            lb  = b[i*LANE_W +: LANE_W];
            d   = (la >= lb) ? (la - lb) : (lb - la);
            sum = sum + SUM_W'(d);
        end
        // R5
        sad_bound_chk: assert (sum <= MAX_SUM);
    end
endmodule

// File: rtl/smac_unit.sv
module smac_unit
    import smac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_in,
    input  logic [3:0]        opcode,
    input  logic              is_signed,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [WORD_W-1:0] acc_in,
    output logic              valid_out,
    output logic [WORD_W-1:0] result
);
    localparam int SADB_W = BYTE_W + $clog2(N_BYTE);
    localparam int SADH_W = HALF_W + $clog2(N_HALF);

    vstate_e                     state_q, state_d;
    logic                        lane_sgn;
    logic [N_HALF-1:0][PROD_W-1:0] prod;
    logic [N_HALF-1:0][WORD_W-1:0] prod_x;
    logic [SADB_W-1:0]           sad_b;
    logic [SADH_W-1:0]           sad_h;
    logic [WORD_W-1:0]           res_d, res_q;
    logic [WORD_W-1:0]           w32_prod;

    assign lane_sgn = is_signed || (opcode == OP_ACC_W32) ||
                      (opcode == OP_ACC_H2) || (opcode == OP_ACC_H0);

    smac_lane_mul #(.LANE_W(HALF_W), .NLANES(N_HALF)) u_lane_mul (
        .a(op_a), .b(op_b), .is_signed(lane_sgn), .prod(prod)
    );

    smac_sad #(.LANE_W(BYTE_W), .NLANES(N_BYTE)) u_sad_byte (
        .a(op_a), .b(op_b), .sum(sad_b)
    );

    smac_sad #(.LANE_W(HALF_W), .NLANES(N_HALF)) u_sad_half (
        .a(op_a), .b(op_b), .sum(sad_h)
    );

    for (genvar i = 0; i < N_HALF; i++) begin : g_ext
        assign prod_x[i] = {{(WORD_W-PROD_W){prod[i][PROD_W-1]}}, prod[i]};
    end

    assign w32_prod = {{32{op_a[31]}}, op_a[31:0]} * {{32{op_b[31]}}, op_b[31:0]};

    always_comb begin
        logic [31:0] pair_lo, pair_hi;
        pair_lo = prod[0][31:0] + prod[1][31:0];
        pair_hi = prod[2][31:0] + prod[3][31:0];
        res_d   = '0;
        case (opcode)
            OP_PAIR_MADD: res_d = {pair_hi, pair_lo};
            OP_SAD_BYTE:  res_d = WORD_W'(sad_b);
            OP_SAD_HALF:  res_d = WORD_W'(sad_h);
            OP_MUL_LO: begin
                for (int i = 0; i < N_HALF; i++)
                    res_d[i*HALF_W +: HALF_W] = prod[i][HALF_W-1:0];
            end
            OP_MUL_HI: begin
                for (int i = 0; i < N_HALF; i++)
                    res_d[i*HALF_W +: HALF_W] = prod[i][2*HALF_W-1:HALF_W];
            end
            OP_MAC_SUM:   res_d = prod_x[0] + prod_x[1] + prod_x[2] + prod_x[3];
            OP_ACC_W32:   res_d = acc_in + w32_prod;
            OP_ACC_H2:    res_d = acc_in + prod_x[0] + prod_x[1];
            OP_ACC_H0:    res_d = acc_in + prod_x[0];
            default:      res_d = '0;
        endcase
    end

    always_comb begin
        state_d = valid_in ? ST_RESULT : ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)           res_q <= '0;
        else if (valid_in) res_q <= res_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:   valid_out = 1'b0;
            ST_RESULT: valid_out = 1'b1;
        endcase
        result = res_q;
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk) rst |=> (!valid_out && result == '0));
    // R2
    vout_follow_chk: assert property (@(posedge clk) disable iff (rst) valid_in |=> valid_out);
    // R2
    vout_drop_chk: assert property (@(posedge clk) disable iff (rst) !valid_in |=> !valid_out);
    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (rst) !valid_in |=> $stable(result));
    // R12
    unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_in && opcode > 4'd8) |=> result == '0);
endmodule

// File: tb/smac_unit_bench.sv
`timescale 1ns/1ps
module smac_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_in = 1'b0;
    logic [3:0]  opcode = '0;
    logic        is_signed = 1'b0;
    logic [63:0] op_a = '0, op_b = '0, acc_in = '0;
    logic        valid_out;
    logic [63:0] result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit mon_en = 1'b0;

    logic        exp_v = 1'b0;
    logic [63:0] exp_r = '0;
    string       rtag  = "R1";
    string       vtag  = "R1";

    always #2.5 clk = ~clk;

    smac_unit u_smac_unit (
        .clk(clk), .rst(rst), .valid_in(valid_in), .opcode(opcode),
        .is_signed(is_signed), .op_a(op_a), .op_b(op_b), .acc_in(acc_in),
        .valid_out(valid_out), .result(result)
    );

    function automatic longint lane16(input logic [63:0] v, input int k, input bit sg);
        logic [15:0] h;
        h = v[16*k +: 16];
        if (sg) return longint'($signed(h));
        return longint'(h);
    endfunction

    function automatic logic [63:0] ref_op(input int op, input bit sg,
                                           input logic [63:0] a, input logic [63:0] b,
                                           input logic [63:0] acc);
        longint p[4];
        longint sp[4];
        longint s, d;
        logic [63:0] r;
        r = '0;
        for (int k = 0; k < 4; k++) begin
            p[k]  = lane16(a, k, sg) * lane16(b, k, sg);
            sp[k] = lane16(a, k, 1'b1) * lane16(b, k, 1'b1);
        end
        case (op)
            0: begin
                s = p[0] + p[1]; r[31:0]  = s[31:0];
                s = p[2] + p[3]; r[63:32] = s[31:0];
            end
            1: begin
                s = 0;
                for (int k = 0; k < 8; k++) begin
                    d = longint'(a[8*k +: 8]) - longint'(b[8*k +: 8]);
                    s += (d < 0) ? -d : d;
                end
                r = s;
            end
            2: begin
                s = 0;
                for (int k = 0; k < 4; k++) begin
                    d = lane16(a, k, 1'b0) - lane16(b, k, 1'b0);
                    s += (d < 0) ? -d : d;
                end
                r = s;
            end
            3: for (int k = 0; k < 4; k++) r[16*k +: 16] = p[k][15:0];
            4: for (int k = 0; k < 4; k++) r[16*k +: 16] = p[k][31:16];
            5: r = p[0] + p[1] + p[2] + p[3];
            6: r = acc + longint'($signed(a[31:0])) * longint'($signed(b[31:0]));
            7: r = acc + sp[0] + sp[1];
            8: r = acc + sp[0];
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input int op, input bit sg);
        case (op)
            0: return sg ? "R4" : "R3";
            1: return "R5";
            2: return "R6";
            3, 4: return sg ? "R4" : "R7";
            5: return sg ? "R4" : "R8";
            6: return "R9";
            7: return "R10";
            8: return "R11";
            default: return "R12";
        endcase
    endfunction

    // Reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            exp_v <= 1'b0;
            exp_r <= '0;
            rtag  <= "R1";
            vtag  <= "R1";
        end else begin
            exp_v <= valid_in;
            vtag  <= "R2";
            if (valid_in) begin
                exp_r <= ref_op(int'(opcode), is_signed, op_a, op_b, acc_in);
                rtag  <= tag_of(int'(opcode), is_signed);
            end else begin
                rtag  <= "R2";
            end
        end
    end

    // Comparison on every falling edge
    always @(negedge clk) begin
        if (mon_en && !done) begin
            checks++;
            if (valid_out !== exp_v) begin
                fails++;
                $display("FAIL %s valid_out got %0b expected %0b", vtag, valid_out, exp_v);
            end
            checks++;
            if (result !== exp_r) begin
                fails++;
                $display("FAIL %s result got %h expected %h (op %0d)", rtag, result, exp_r, opcode);
            end
        end
    end

    task automatic issue(input int op, input bit sg, input logic [63:0] a,
                         input logic [63:0] b, input logic [63:0] acc);
        @(negedge clk);
        valid_in  = 1'b1;
        opcode    = 4'(op);
        is_signed = sg;
        op_a      = a;
        op_b      = b;
        acc_in    = acc;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            valid_in = 1'b0;
            op_a     = {$urandom, $urandom};
            opcode   = 4'($urandom);
        end
    endtask

    function automatic logic [63:0] pattern(input int k, input bit side);
        case (k)
            0: return 64'h8000_8000_8000_8000;
            1: return 64'hFFFF_FFFF_FFFF_FFFF;
            2: return side ? 64'h0 : 64'hFFFF_FFFF_FFFF_FFFF;
            3: return side ? 64'h8000_7FFF_0001_8000 : 64'h7FFF_8000_FFFF_7FFF;
            default: return {$urandom, $urandom};
        endcase
    endfunction

    initial begin
        @(posedge clk);
        mon_en = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state seen by the monitor during the reset cycles
        rst = 1'b0;
        for (int op = 0; op < 16; op++) begin
            for (int sg = 0; sg < 2; sg++) begin
                for (int k = 0; k < 7; k++) begin
                    issue(op, sg[0], pattern(k, 1'b0), pattern(k, 1'b1), {$urandom, $urandom});
                    if (k == 3) idle(2);
                end
            end
            idle(1);
        end
        // R2 back-to-back transfers followed by a long hold
        for (int k = 0; k < 40; k++)
            issue(int'($urandom_range(0, 15)), 1'($urandom), {$urandom, $urandom},
                  {$urandom, $urandom}, {$urandom, $urandom});
        idle(5);
        // R1 reset while a result is pending
        issue(0, 1'b1, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, '0);
        @(negedge clk);
        rst = 1'b1;
        valid_in = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        valid_in = 1'b0;
        idle(3);
        issue(6, 1'b0, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
        idle(3);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog run did not finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule